// File: doc/BRIEF.md
# Speculation-Control Register with Deferred Cache Flush

This block holds a 64-bit control word for the data-cache unit. It is read and written over a simple register port. One bit of the word disables speculative execution. While that bit is set, the block tells the pipeline to treat every load and store as serializing and to stop aggressive instruction prefetch. When the bit goes from 0 to 1, the block sends a single-cycle pulse that clears the branch history predictor. The other writable fields drive level outputs for the address-translation masks and for the cache enables.

The block also controls when a level-2 cache flush may begin, and it relates that flush to a synchronisation barrier. If a flush request arrives while speculation is disabled, the block records it but does not start it. Barriers issued in that state are acknowledged without waiting for the flush. When software clears the speculation-disable bit, the recorded flush is released to the cache. Any barrier issued after that point is held until the cache reports that the flush is done.

Top module: `spec_ctl_reg`

## Requirements
- R1: An asynchronous power-on reset (`por_n` low) clears every stored bit, the flush state and the barrier state. A watchdog, external or software reset input that is high at a rising clock edge does the same, and it takes priority over a write in that cycle.
- R2: Reading the register returns 0 in every position except bits 41:21, bit 3 and bit 2. Writes to any other position are discarded.
- R3: A write stores the physical mask at bits 40:33 and the virtual mask at bits 32:25. It stores the physical read, physical write, virtual read and virtual write enables at bits 24, 23, 22 and 21, the data-cache enable at bit 3 and the instruction-cache enable at bit 2. Each field drives its own output starting in the cycle after the write edge.
- R4: `bhp_clear` is high for exactly one cycle, the cycle after a write edge that changes bit 41 from 0 to 1. Writing 1 over a stored 1 gives no pulse.
- R5: `serial_ldst` and `pf_disable` are high exactly while stored bit 41 is 1.
- R6: A flush request made while bit 41 is 0 raises `flush_start` for one cycle, the cycle after the request edge.
- R7: A flush request made while bit 41 is 1 does not start a flush. It starts, with `flush_start` high in the cycle after the write edge, when bit 41 is written back to 0.
- R8: Further flush requests made while a flush is pending or in progress merge into it. They produce no extra `flush_start`, either at once or after `flush_done`.
- R9: When no flush is pending or in progress, a barrier request is acknowledged (`bar_ack` high for one cycle) in the cycle after the request edge.
- R10: A barrier requested while bit 41 is 1 is acknowledged in the cycle after the request, even if a flush is pending.
- R11: A barrier requested while a released flush is in progress keeps `bar_ack` low until `flush_done` is sampled. It is acknowledged in the cycle after that edge.
- R12: When a write and a flush request fall in the same cycle, both take effect, and the new value of bit 41 decides whether the flush starts or is held pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| wdog_rst | input | 1 | Watchdog reset, synchronous, active high |
| ext_rst | input | 1 | Externally initiated reset, synchronous, active high |
| sw_rst | input | 1 | Software-initiated reset, synchronous, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Masked stored register value |
| flush_req | input | 1 | Flush request strobe from the cache control register |
| flush_start | output | 1 | One-cycle flush launch toward the cache |
| flush_done | input | 1 | Cache reports that the launched flush has finished |
| bar_req | input | 1 | Barrier request strobe |
| bar_ack | output | 1 | Barrier acknowledge, one cycle |
| bhp_clear | output | 1 | Branch-predictor clear pulse |
| serial_ldst | output | 1 | Treat loads and stores as serializing |
| pf_disable | output | 1 | Disable aggressive instruction prefetch |
| pmask | output | 8 | Physical address mask field |
| vmask | output | 8 | Virtual address mask field |
| pr_en | output | 1 | Physical read enable |
| pw_en | output | 1 | Physical write enable |
| vr_en | output | 1 | Virtual read enable |
| vw_en | output | 1 | Virtual write enable |
| dc_en | output | 1 | Data-cache enable |
| ic_en | output | 1 | Instruction-cache enable |

## Verification
A walking-one write across all 64 positions targets the read mask. A design that stores an unused bit, or drops a field bit, returns a word that differs from the mask computed in the bench. The flush sequences separate three cases:
- a barrier issued while speculation is off, which a faulty design would hold until the flush completes;
- a barrier issued after release, which a faulty design would acknowledge early;
- a request that arrives together with a write, which a faulty design would judge on the old bit value and so start or defer wrongly.

Repeated writes of 1 to bit 41, and repeated flush requests while a flush is busy, catch a design that pulses the predictor clear more than once or queues a second flush.

// File: rtl/spec_ctl_pkg.sv
package spec_ctl_pkg;
  localparam int REG_W    = 64;
  localparam int MASK_W   = 8;
  localparam int SPEC_BIT = 41;
  localparam int PM_LSB   = 33;
  localparam int VM_LSB   = 25;
  localparam int PR_BIT   = 24;
  localparam int PW_BIT   = 23;
  localparam int VR_BIT   = 22;
  localparam int VW_BIT   = 21;
  localparam int DC_BIT   = 3;
  localparam int IC_BIT   = 2;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_PEND = 2'd1,
    FL_BUSY = 2'd2
  } fl_state_t;

  // Writable positions: the speculation bit down to the lowest enable, plus the two cache enables.
  function automatic logic [REG_W-1:0] build_wr_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = VW_BIT; i <= SPEC_BIT; i++) m[i] = 1'b1;
    m[DC_BIT] = 1'b1;
    m[IC_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] WR_MASK = build_wr_mask();
endpackage

// File: rtl/spec_ctl_regs.sv
module spec_ctl_regs
  import spec_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             spec_q,
  output logic             spec_new,
  output logic             pred_clr
);
  logic [REG_W-1:0] word_q, word_nxt;
  logic             spec_prev_q, spec_prev_nxt;

  always_comb begin
    word_nxt      = word_q;
    spec_prev_nxt = word_q[SPEC_BIT];
    if (sync_clr) begin
      word_nxt      = '0;
      spec_prev_nxt = 1'b0;
    end else if (wr_en) begin
      word_nxt = wdata & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      spec_prev_q <= 1'b0;
    end else begin
      word_q      <= word_nxt;
      spec_prev_q <= spec_prev_nxt;
    end
  end

  assign rdata    = word_q;
  assign spec_q   = word_q[SPEC_BIT];
  assign spec_new = wr_en ? wdata[SPEC_BIT] : word_q[SPEC_BIT];
  assign pred_clr = word_q[SPEC_BIT] & ~spec_prev_q;
endmodule

// File: rtl/spec_ctl_flush.sv
module spec_ctl_flush
  import spec_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic flush_req,
  input  logic spec_q,
  input  logic spec_new,
  input  logic flush_done,
  output logic flush_start,
  output logic flush_busy,
  output logic flush_block
);
  fl_state_t st_q, st_nxt;
  logic      start_q, start_nxt;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      FL_IDLE: if (flush_req) st_nxt = spec_new ? FL_PEND : FL_BUSY;
      FL_PEND: if (!spec_new) st_nxt = FL_BUSY;
      FL_BUSY: if (flush_done) st_nxt = FL_IDLE;
      default: st_nxt = FL_IDLE;
    endcase
    start_nxt = (st_nxt == FL_BUSY) && (st_q != FL_BUSY);
    if (sync_clr) begin
      st_nxt    = FL_IDLE;
      start_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FL_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      start_q <= start_nxt;
    end
  end

  assign flush_start = start_q;
  assign flush_busy  = (st_q == FL_BUSY);
  // A pending flush blocks barriers only once it is about to be released.
  assign flush_block = (st_q == FL_BUSY) || ((st_q == FL_PEND) && !spec_q);
endmodule

// File: rtl/spec_ctl_bar.sv
module spec_ctl_bar (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic bar_req,
  input  logic flush_block,
  output logic bar_ack
);
  logic wait_q, wait_nxt;

  always_comb begin
    wait_nxt = wait_q;
    if (sync_clr)                     wait_nxt = 1'b0;
    else if (wait_q && !flush_block)  wait_nxt = 1'b0;
    else if (!wait_q && bar_req)      wait_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_nxt;
  end

  assign bar_ack = wait_q & ~flush_block;
endmodule

// File: rtl/spec_ctl_reg.sv
module spec_ctl_reg
  import spec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wdog_rst,
  input  logic              ext_rst,
  input  logic              sw_rst,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              flush_req,
  output logic              flush_start,
  input  logic              flush_done,
  input  logic              bar_req,
  output logic              bar_ack,
  output logic              bhp_clear,
  output logic              serial_ldst,
  output logic              pf_disable,
  output logic [MASK_W-1:0] pmask,
  output logic [MASK_W-1:0] vmask,
  output logic              pr_en,
  output logic              pw_en,
  output logic              vr_en,
  output logic              vw_en,
  output logic              dc_en,
  output logic              ic_en
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       sync_clr;
  logic       spec_q, spec_new;
  logic       flush_busy, flush_block;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n    = rst_sync_q[1];
  assign sync_clr = wdog_rst | ext_rst | sw_rst;

  spec_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .spec_q   (spec_q),
    .spec_new (spec_new),
    .pred_clr (bhp_clear)
  );

  spec_ctl_flush u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (sync_clr),
    .flush_req   (flush_req),
    .spec_q      (spec_q),
    .spec_new    (spec_new),
    .flush_done  (flush_done),
    .flush_start (flush_start),
    .flush_busy  (flush_busy),
    .flush_block (flush_block)
  );

  spec_ctl_bar u_bar (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (sync_clr),
    .bar_req     (bar_req),
    .flush_block (flush_block),
    .bar_ack     (bar_ack)
  );

  assign serial_ldst = spec_q;
  assign pf_disable  = spec_q;
  assign pmask       = reg_rdata[PM_LSB +: MASK_W];
  assign vmask       = reg_rdata[VM_LSB +: MASK_W];
  assign pr_en       = reg_rdata[PR_BIT];
  assign pw_en       = reg_rdata[PW_BIT];
  assign vr_en       = reg_rdata[VR_BIT];
  assign vw_en       = reg_rdata[VW_BIT];
  assign dc_en       = reg_rdata[DC_BIT];
  assign ic_en       = reg_rdata[IC_BIT];
endmodule

// File: rtl/spec_ctl_chk.sv
module spec_ctl_chk
  import spec_ctl_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic [REG_W-1:0] reg_rdata,
  input logic             flush_start,
  input logic             flush_busy,
  input logic             bar_ack,
  input logic             bhp_clear
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata & ~WR_MASK) == '0);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!por_n)
    bhp_clear |=> !bhp_clear);

  a_r4_pulse_with_bit: assert property (@(posedge clk) disable iff (!por_n)
    bhp_clear |-> reg_rdata[SPEC_BIT]);

  a_r7_no_start_when_off: assert property (@(posedge clk) disable iff (!por_n)
    flush_start |-> !reg_rdata[SPEC_BIT]);

  a_r8_start_single: assert property (@(posedge clk) disable iff (!por_n)
    flush_start |=> !flush_start);

  a_r11_ack_not_busy: assert property (@(posedge clk) disable iff (!por_n)
    bar_ack |-> !flush_busy);

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!por_n)
    bar_ack |=> !bar_ack);
endmodule

bind spec_ctl_reg spec_ctl_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .reg_rdata   (reg_rdata),
  .flush_start (flush_start),
  .flush_busy  (flush_busy),
  .bar_ack     (bar_ack),
  .bhp_clear   (bhp_clear)
);

// File: tb/spec_ctl_reg_tb.sv
`timescale 1ns/1ps
module spec_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        por_n, wdog_rst, ext_rst, sw_rst;
  logic        reg_wr_en;
  logic [63:0] reg_wdata, reg_rdata;
  logic        flush_req, flush_start, flush_done;
  logic        bar_req, bar_ack;
  logic        bhp_clear, serial_ldst, pf_disable;
  logic [7:0]  pmask, vmask;
  logic        pr_en, pw_en, vr_en, vw_en, dc_en, ic_en;
  int          checks = 0;
  int          errors = 0;
  bit          done_flag = 0;

  always #2.5 clk = ~clk;

  spec_ctl_reg u_dut (
    .clk(clk), .por_n(por_n), .wdog_rst(wdog_rst), .ext_rst(ext_rst), .sw_rst(sw_rst),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flush_req(flush_req), .flush_start(flush_start), .flush_done(flush_done),
    .bar_req(bar_req), .bar_ack(bar_ack), .bhp_clear(bhp_clear),
    .serial_ldst(serial_ldst), .pf_disable(pf_disable), .pmask(pmask), .vmask(vmask),
    .pr_en(pr_en), .pw_en(pw_en), .vr_en(vr_en), .vw_en(vw_en), .dc_en(dc_en), .ic_en(ic_en)
  );

  localparam logic [63:0] SPEC = 64'd1 << 41;

  function automatic logic [63:0] exp_mask();
    logic [63:0] m = '0;
    for (int b = 21; b <= 41; b++) m[b] = 1'b1;
    m[3] = 1'b1;
    m[2] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [63:0] v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    por_n = 1'b0; wdog_rst = 0; ext_rst = 0; sw_rst = 0;
    reg_wr_en = 0; reg_wdata = '0; flush_req = 0; flush_done = 0; bar_req = 0;
    repeat (3) step();
    chk("R1 por rdata", reg_rdata, 64'd0);
    chk("R1 por outputs", {62'd0, flush_start, bar_ack}, 64'd0);
    por_n = 1'b1;
    repeat (3) step();

    // R2/R3: walking one across every bit position
    for (int i = 0; i < 64; i++) begin
      wr(64'd1 << i);
      chk("R2 walking one", reg_rdata, (64'd1 << i) & exp_mask());
    end
    wr('1);
    chk("R2 all ones", reg_rdata, exp_mask());

    // R3 field outputs
    wr((64'hA5 << 33) | (64'h3C << 25) | (64'd1 << 24) | (64'd1 << 22) | (64'd1 << 3));
    chk("R3 pmask", {56'd0, pmask}, 64'hA5);
    chk("R3 vmask", {56'd0, vmask}, 64'h3C);
    chk("R3 enables", {58'd0, pr_en, pw_en, vr_en, vw_en, dc_en, ic_en}, 64'b101010);
    wr((64'd1 << 23) | (64'd1 << 21) | (64'd1 << 2));
    chk("R3 enables b", {58'd0, pr_en, pw_en, vr_en, vw_en, dc_en, ic_en}, 64'b010101);

    // R1: each synchronous reset beats a same-cycle write
    for (int k = 0; k < 3; k++) begin
      wr('1);
      wdog_rst = (k == 0); ext_rst = (k == 1); sw_rst = (k == 2);
      wr('1);
      wdog_rst = 0; ext_rst = 0; sw_rst = 0;
      chk("R1 sync reset rdata", reg_rdata, 64'd0);
      chk("R1 sync reset spec outputs", {62'd0, serial_ldst, pf_disable}, 64'd0);
    end

    // R4/R5 predictor clear pulse and spec outputs
    wr(64'd0);
    wr(SPEC);
    chk("R4 pulse on set", {63'd0, bhp_clear}, 64'd1);
    chk("R5 spec outputs on", {62'd0, serial_ldst, pf_disable}, 64'd3);
    step();
    chk("R4 pulse one cycle", {63'd0, bhp_clear}, 64'd0);
    wr(SPEC);
    chk("R4 no pulse on rewrite", {63'd0, bhp_clear}, 64'd0);
    wr(64'd0);
    chk("R5 spec outputs off", {62'd0, serial_ldst, pf_disable}, 64'd0);
    chk("R4 no pulse on clear", {63'd0, bhp_clear}, 64'd0);

    // R9: barrier with no flush
    bar_req = 1; step(); bar_req = 0;
    chk("R9 ack next cycle", {63'd0, bar_ack}, 64'd1);
    step();
    chk("R9 ack one cycle", {63'd0, bar_ack}, 64'd0);

    // R6/R11/R8: immediate flush, barrier waits, merge
    flush_req = 1; step(); flush_req = 0;
    chk("R6 start next cycle", {63'd0, flush_start}, 64'd1);
    flush_req = 1; step(); flush_req = 0;
    chk("R8 merged while busy", {63'd0, flush_start}, 64'd0);
    bar_req = 1; step(); bar_req = 0;
    chk("R11 ack held", {63'd0, bar_ack}, 64'd0);
    repeat (4) step();
    chk("R11 ack still held", {63'd0, bar_ack}, 64'd0);
    flush_done = 1; step(); flush_done = 0;
    chk("R11 ack after done", {63'd0, bar_ack}, 64'd1);
    chk("R8 no restart", {63'd0, flush_start}, 64'd0);
    repeat (3) begin
      step();
      chk("R8 no queued flush", {62'd0, flush_start, bar_ack}, 64'd0);
    end

    // R7/R10: deferred flush while speculation disabled
    wr(SPEC);
    flush_req = 1; step(); flush_req = 0;
    chk("R7 held pending", {63'd0, flush_start}, 64'd0);
    flush_req = 1; step(); flush_req = 0;
    chk("R8 merged while pending", {63'd0, flush_start}, 64'd0);
    bar_req = 1; step(); bar_req = 0;
    chk("R10 ack despite pending", {63'd0, bar_ack}, 64'd1);
    wr(64'd0);
    chk("R7 start on release", {63'd0, flush_start}, 64'd1);
    bar_req = 1; step(); bar_req = 0;
    chk("R11 ack held after release", {63'd0, bar_ack}, 64'd0);
    flush_done = 1; step(); flush_done = 0;
    chk("R11 ack after released done", {63'd0, bar_ack}, 64'd1);
    step();

    // R12: same-cycle write and request
    reg_wr_en = 1; reg_wdata = SPEC; flush_req = 1; step(); reg_wr_en = 0; flush_req = 0;
    chk("R12 set+req pending", {63'd0, flush_start}, 64'd0);
    chk("R12 write honoured", reg_rdata, SPEC);
    reg_wr_en = 1; reg_wdata = 64'd0; step(); reg_wr_en = 0;
    chk("R12 release start", {63'd0, flush_start}, 64'd1);
    flush_done = 1; step(); flush_done = 0;
    wr(SPEC);
    reg_wr_en = 1; reg_wdata = 64'd0; flush_req = 1; step(); reg_wr_en = 0; flush_req = 0;
    chk("R12 clear+req starts", {63'd0, flush_start}, 64'd1);
    flush_done = 1; step(); flush_done = 0;

    // R1: power-on reset mid-operation
    wr('1);
    flush_req = 1; step(); flush_req = 0;
    por_n = 0; #1;
    chk("R1 async por", reg_rdata, 64'd0);
    por_n = 1;
    repeat (3) step();
    bar_req = 1; step(); bar_req = 0;
    chk("R1 flush state cleared", {63'd0, bar_ack}, 64'd1);
    step();
    finish_run();
  end
endmodule